// File: doc/BRIEF.md
# PCI Host Bridge Register Interface

This block is the CPU-facing register slave of a PCI host controller. A simple 32-bit request/response bus reaches a window of 0x224 bytes. The low part of the window holds the bridge's own 64-word configuration header. Above it sit three bridge control registers and a data port. The three registers are a configuration target address, a memory base and an I/O base. Reading or writing the data port starts a 4-byte configuration cycle. An external configuration-cycle engine runs that cycle, aimed at the address held in the target register. The CPU bus stalls until the engine reports completion.

The block also relocates a fixed 256 KiB I/O window. A local offset inside the window is combined with the upper bits of the I/O base to form the PCI I/O address. It also gathers the interrupt levels of the devices on the bus onto four interrupt outputs. Each device is steered by its device number.

Top module: `pcih_regif`

## Requirements
- R1: After reset, the header word at offset 0x004 reads 0x0290_0080. This sets command bit 7 (wait-cycle control) and status bits 4 (capability list), 7 (fast back-to-back capable) and 9 (medium DEVSEL timing). Every other header word reads 0, and so do offsets 0x1C0, 0x1C4 and 0x1C8.
- R2: Offsets 0x000 to 0x0FC read and write the local header, one full 32-bit word per offset. Byte 0 of the word is on bits 7:0.
- R3: Offset 0x1C0, the configuration target address, stores all 32 written bits.
- R4: Offset 0x1C4, the memory base, keeps written bits 31:24 and bit 0. All other bits read as 0.
- R5: Offset 0x1C8, the I/O base, keeps written bits 31:18 and bit 0. All other bits read as 0.
- R6: `io_addr` equals the I/O base bits 31:18 followed by the 18-bit window offset `io_off`. It follows both without a clock.
- R7: A read of 0x220 drives `cfg_req` high with `cfg_write`=0 and `cfg_addr` equal to the value at 0x1C0. `cfg_req` holds steady until `cfg_done`, and `bus_ready` stays low meanwhile. The response comes in the cycle after `cfg_done` and carries `cfg_rdata`.
- R8: A write of 0x220 runs the same cycle with `cfg_write`=1 and `cfg_wdata` equal to the written word. Its response returns data 0.
- R9: Unlisted offsets read as 0 and ignore writes. These are 0x100–0x1BC, 0x1CC–0x21C and 0x224–0x3FC.
- R10: An access is rejected if `bus_be` is not 4'hF or `bus_addr[1:0]` is not 0. A rejected access answers with `rsp_err`=1 and data 0. It changes no register and starts no configuration cycle.
- R11: `irq_out[k]` is the OR of the `irq_lvl[i]` whose `irq_devfn` byte i has bits 7:3 equal to k. A source whose device number is 4 or more reaches no output.
- R12: `bus_ready` is high whenever no configuration cycle is pending. Any accepted access other than a valid data-port access answers exactly one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | CPU access request |
| bus_ready | output | 1 | Access accepted when high with bus_valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is legal |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_write | output | 1 | Configuration cycle direction |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Engine completion strobe |
| cfg_rdata | input | 32 | Engine read data |
| io_off | input | 18 | Offset inside the I/O window |
| io_addr | output | 32 | Translated PCI I/O address |
| irq_devfn | input | 64 | Device/function byte of each of 8 sources |
| irq_lvl | input | 8 | Interrupt level of each source |
| irq_out | output | 4 | Routed interrupt outputs |

## Verification
Some properties are checked on every cycle. The handshake toward the engine keeps its request and its fields steady until completion, and the CPU bus stays stalled meanwhile. A completion is always followed by an error-free response, and a register access always answers after one cycle. An error response never carries data, and the base registers never hold bits outside their kept fields. Other behaviour shows only in the bench's scenarios. This covers the reset contents, each write mask as seen on readback, and the data returned from the engine. It also covers rejected and unlisted accesses leaving state untouched, the I/O window arithmetic and the interrupt steering.

// File: rtl/pcih_pkg.sv
package pcih_pkg;
  localparam int unsigned PCIH_DW = 32;

  localparam logic [9:0] OFS_CADDR  = 10'h1C0;
  localparam logic [9:0] OFS_MBASE  = 10'h1C4;
  localparam logic [9:0] OFS_IOBASE = 10'h1C8;
  localparam logic [9:0] OFS_PORT   = 10'h220;
  localparam logic [9:0] OFS_HDRTOP = 10'h0FC;

  localparam logic [31:0] MBASE_KEEP  = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_KEEP = 32'hFFFC_0001;

  // command: wait-cycle control (bit 7); status: cap list (4), fast b2b (7), medium devsel (9)
  localparam logic [15:0] CMD_RST  = 16'h0080;
  localparam logic [15:0] STAT_RST = 16'h0290;
  localparam logic [31:0] HDR_W1_RST = {STAT_RST, CMD_RST};

  typedef enum logic [2:0] {
    RG_HDR, RG_CADDR, RG_MBASE, RG_IOBASE, RG_PORT, RG_NONE
  } pcih_rgn_e;

  typedef enum logic {CP_IDLE, CP_BUSY} pcih_cp_e;

  function automatic pcih_rgn_e pcih_decode(input logic [9:0] a);
    if (a <= OFS_HDRTOP)     return RG_HDR;
    else if (a == OFS_CADDR)  return RG_CADDR;
    else if (a == OFS_MBASE)  return RG_MBASE;
    else if (a == OFS_IOBASE) return RG_IOBASE;
    else if (a == OFS_PORT)   return RG_PORT;
    else                      return RG_NONE;
  endfunction
endpackage

// File: rtl/pcih_hdr_store.sv
module pcih_hdr_store #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  parameter logic [DW-1:0] W1_RST = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [DW-1:0] RST_V = (g == 1) ? W1_RST : '0;
    logic          we;
    logic [DW-1:0] word_d;

    always_comb begin
      we     = wr_en && (idx == g[$clog2(WORDS)-1:0]);
      word_d = we ? wdata : mem_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= RST_V;
      else if (we) mem_q[g] <= word_d;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/pcih_cfg_port.sv
module pcih_cfg_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [DW-1:0] start_wdata,
  input  logic [DW-1:0] tgt_addr,
  input  logic          cfg_done,
  input  logic [DW-1:0] cfg_rdata,
  output logic          cfg_req,
  output logic          cfg_write,
  output logic [DW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_wdata,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] fin_rdata
);
  import pcih_pkg::*;

  pcih_cp_e      st_q, st_d;
  logic          wr_q, wr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          ld_en;

  always_comb begin
    st_d  = st_q;
    ld_en = 1'b0;
    wr_d  = start_write;
    wd_d  = start_wdata;
    case (st_q)
      CP_IDLE: if (start) begin
        st_d  = CP_BUSY;
        ld_en = 1'b1;
      end
      CP_BUSY: if (cfg_done) st_d = CP_IDLE;
      default: st_d = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CP_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      wd_q <= '0;
    end else if (ld_en) begin
      wr_q <= wr_d;
      wd_q <= wd_d;
    end
  end

  always_comb begin
    busy      = (st_q == CP_BUSY);
    cfg_req   = busy;
    cfg_write = wr_q;
    cfg_wdata = wd_q;
    cfg_addr  = tgt_addr;
    fin       = busy && cfg_done;
    fin_rdata = wr_q ? '0 : cfg_rdata;
  end
endmodule

// File: rtl/pcih_irq_route.sv
module pcih_irq_route #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned NIRQ = 4
) (
  input  logic [NSRC*8-1:0] devfn,
  input  logic [NSRC-1:0]   lvl,
  output logic [NIRQ-1:0]   irq
);
  for (genvar k = 0; k < NIRQ; k++) begin : g_out
    logic [NSRC-1:0] hit;
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = lvl[i] && (devfn[i*8+3 +: 5] == k[4:0]);
    end
    assign irq[k] = |hit;
  end
endmodule

// File: rtl/pcih_regif.sv
module pcih_regif #(
  parameter int unsigned AW       = 10,
  parameter int unsigned NSRC     = 8,
  parameter int unsigned NIRQ     = 4,
  parameter int unsigned IO_WIN_W = 18,
  parameter int unsigned HDR_WORDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [AW-1:0]        bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic                 cfg_req,
  output logic                 cfg_write,
  output logic [31:0]          cfg_addr,
  output logic [31:0]          cfg_wdata,
  input  logic                 cfg_done,
  input  logic [31:0]          cfg_rdata,
  input  logic [IO_WIN_W-1:0]  io_off,
  output logic [31:0]          io_addr,
  input  logic [NSRC*8-1:0]    irq_devfn,
  input  logic [NSRC-1:0]      irq_lvl,
  output logic [NIRQ-1:0]      irq_out
);
  import pcih_pkg::*;

  localparam int unsigned DW    = 32;
  localparam int unsigned HIX_W = $clog2(HDR_WORDS);

  pcih_rgn_e     rg;
  logic          accept, bad, wr_ok, rd_ok;
  logic          busy, fin, start;
  logic [DW-1:0] fin_rdata, hdr_rdata, rd_mux;

  logic [DW-1:0] par_q, par_d, mbr_q, mbr_d, iobr_q, iobr_d;
  logic          par_en, mbr_en, iobr_en, hdr_en;

  logic          rv_q, rv_d, re_q, re_d;
  logic [DW-1:0] rd_q, rd_d;

  // decode and qualification
  always_comb begin
    rg      = pcih_decode(bus_addr);
    accept  = bus_valid && bus_ready;
    bad     = (bus_be != 4'hF) || (bus_addr[1:0] != 2'b00);
    wr_ok   = accept && bus_write && !bad;
    rd_ok   = accept && !bad;
    hdr_en  = wr_ok && (rg == RG_HDR);
    par_en  = wr_ok && (rg == RG_CADDR);
    mbr_en  = wr_ok && (rg == RG_MBASE);
    iobr_en = wr_ok && (rg == RG_IOBASE);
    start   = rd_ok && (rg == RG_PORT);
    par_d   = bus_wdata;
    mbr_d   = bus_wdata & MBASE_KEEP;
    iobr_d  = bus_wdata & IOBASE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else if (par_en) par_q <= par_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbr_q <= '0;
    else if (mbr_en) mbr_q <= mbr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iobr_q <= '0;
    else if (iobr_en) iobr_q <= iobr_d;
  end

  pcih_hdr_store #(
    .WORDS (HDR_WORDS),
    .DW    (DW),
    .W1_RST(HDR_W1_RST)
  ) u_hdr (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(hdr_en),
    .idx  (bus_addr[HIX_W+1:2]),
    .wdata(bus_wdata),
    .rdata(hdr_rdata)
  );

  pcih_cfg_port #(.DW(DW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_write(bus_write),
    .start_wdata(bus_wdata),
    .tgt_addr   (par_q),
    .cfg_done   (cfg_done),
    .cfg_rdata  (cfg_rdata),
    .cfg_req    (cfg_req),
    .cfg_write  (cfg_write),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .fin        (fin),
    .fin_rdata  (fin_rdata)
  );

  assign bus_ready = !busy;

  // read multiplexer
  always_comb begin
    case (rg)
      RG_HDR:    rd_mux = hdr_rdata;
      RG_CADDR:  rd_mux = par_q;
      RG_MBASE:  rd_mux = mbr_q;
      RG_IOBASE: rd_mux = iobr_q;
      default:   rd_mux = '0;
    endcase
  end

  // response next state
  always_comb begin
    rv_d = fin || (accept && !start);
    re_d = accept && bad;
    if (fin)                    rd_d = fin_rdata;
    else if (accept && !bad && !bus_write) rd_d = rd_mux;
    else                        rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      re_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      re_q <= re_d;
      rd_q <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_err   = re_q;
  assign rsp_rdata = rd_q;

  // I/O window relocation
  assign io_addr = {iobr_q[DW-1:IO_WIN_W], io_off};

  pcih_irq_route #(.NSRC(NSRC), .NIRQ(NIRQ)) u_irq (
    .devfn(irq_devfn),
    .lvl  (irq_lvl),
    .irq  (irq_out)
  );
endmodule

// File: rtl/pcih_regif_chk.sv
module pcih_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [9:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        cfg_req,
  input logic        cfg_done,
  input logic        cfg_write,
  input logic [31:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] mbr_q,
  input logic [31:0] iobr_q
);
  assert_err_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done) |=> cfg_req);

  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done) |=> ($stable(cfg_addr) && $stable(cfg_write) && $stable(cfg_wdata)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !bus_ready);

  assert_port_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_addr == 10'h220 && bus_be == 4'hF) |=> (cfg_req && !rsp_valid));

  assert_done_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_done) |=> (rsp_valid && !rsp_err));

  assert_reg_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_addr != 10'h220) |=> rsp_valid);

  assert_mbase_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbr_q & 32'h00FF_FFFE) == 32'h0);

  assert_iobase_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iobr_q & 32'h0003_FFFE) == 32'h0);
endmodule

bind pcih_regif pcih_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_addr (bus_addr),
  .bus_be   (bus_be),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .cfg_req  (cfg_req),
  .cfg_done (cfg_done),
  .cfg_write(cfg_write),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .mbr_q    (mbr_q),
  .iobr_q   (iobr_q)
);

// File: tb/pcih_regif_test.sv
module pcih_regif_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic        bus_ready;
  logic [9:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_req, cfg_write, cfg_done;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic [17:0] io_off;
  logic [31:0] io_addr;
  logic [63:0] irq_devfn;
  logic [7:0]  irq_lvl;
  logic [3:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  logic        cfg_allowed = 1'b0;
  logic        exp_cfg_wr;
  logic [31:0] exp_cfg_addr, exp_cfg_wd;
  int          cfg_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcih_regif uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .cfg_rdata(cfg_rdata),
    .io_off(io_off), .io_addr(io_addr),
    .irq_devfn(irq_devfn), .irq_lvl(irq_lvl), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: queue the expected response, then present the access
  task automatic acc(input logic wr, input logic [9:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] ed, input logic ee,
                     input string req);
    exp_q.push_back({ee, ed});
    tag_q.push_back(req);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr32(input logic [9:0] a, input logic [31:0] d, input string req);
    acc(1'b1, a, 4'hF, d, 32'h0, 1'b0, req);
  endtask

  task automatic rd32(input logic [9:0] a, input logic [31:0] e, input string req);
    acc(1'b0, a, 4'hF, 32'h0, e, 1'b0, req);
  endtask

  // monitor: pops and compares each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 actual=unexpected response expected=none");
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rsp_err, rsp_rdata}, e);
      end
    end
  end

  // configuration engine model: completes three cycles after the request
  always @(negedge clk) begin
    if (!rst_n) begin
      cfg_done <= 1'b0; cfg_cnt <= 0;
    end else if (cfg_done) begin
      cfg_done <= 1'b0;
    end else if (cfg_req) begin
      if (!cfg_allowed) begin
        checks++; fails++;
        $display("FAIL R10 actual=cfg_req expected=no cycle");
        cfg_allowed = 1'b1;
      end
      if (bus_ready) begin
        checks++; fails++;
        $display("FAIL R7 actual=ready expected=stalled");
      end
      if (cfg_cnt == 2) begin
        check("R7", {cfg_write, cfg_addr}, {exp_cfg_wr, exp_cfg_addr});
        if (exp_cfg_wr) check("R8", {1'b0, cfg_wdata}, {1'b0, exp_cfg_wd});
        cfg_rdata <= cfg_addr ^ 32'hC0FF_EE00;
        cfg_done  <= 1'b1;
        cfg_cnt   <= 0;
      end else begin
        cfg_cnt <= cfg_cnt + 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_be = 4'hF; bus_wdata = '0; cfg_rdata = '0; io_off = '0;
    irq_devfn = {8'hF8, 8'hF8, 8'hF8, 8'hF8, 8'h00, 8'h28, 8'h13, 8'h08};
    irq_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: idle ready
    check("R12", {32'h0, bus_ready}, 33'h1);

    // R1 reset contents
    rd32(10'h004, 32'h0290_0080, "R1");
    rd32(10'h000, 32'h0, "R1");
    rd32(10'h0FC, 32'h0, "R1");
    rd32(10'h1C0, 32'h0, "R1");
    rd32(10'h1C4, 32'h0, "R1");
    rd32(10'h1C8, 32'h0, "R1");

    // R2 header words
    wr32(10'h010, 32'hDEAD_BEEF, "R2");
    wr32(10'h0FC, 32'h1234_5678, "R2");
    rd32(10'h010, 32'hDEAD_BEEF, "R2");
    rd32(10'h0FC, 32'h1234_5678, "R2");
    wr32(10'h004, 32'h0000_0006, "R2");
    rd32(10'h004, 32'h0000_0006, "R2");

    // R3 target address
    wr32(10'h1C0, 32'h8000_0A5C, "R3");
    rd32(10'h1C0, 32'h8000_0A5C, "R3");

    // R4 memory base mask
    wr32(10'h1C4, 32'hA5A5_A5A5, "R4");
    rd32(10'h1C4, 32'hA500_0001, "R4");

    // R5 / R6 I/O base and window
    wr32(10'h1C8, 32'hFFFF_FFFF, "R5");
    rd32(10'h1C8, 32'hFFFC_0001, "R5");
    io_off = 18'h3FFFF; #1;
    check("R6", {1'b0, io_addr}, {1'b0, 32'hFFFF_FFFF});
    io_off = 18'h12345; #1;
    check("R6", {1'b0, io_addr}, {1'b0, 32'hFFFD_2345});
    wr32(10'h1C8, 32'h1234_5678, "R5");
    rd32(10'h1C8, 32'h1234_0000, "R5");
    io_off = 18'h0; #1;
    check("R6", {1'b0, io_addr}, {1'b0, 32'h1234_0000});

    // R7 data port read
    exp_cfg_addr = 32'h8000_0A5C; exp_cfg_wr = 1'b0; exp_cfg_wd = '0;
    cfg_allowed = 1'b1;
    rd32(10'h220, 32'h8000_0A5C ^ 32'hC0FF_EE00, "R7");
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    cfg_allowed = 1'b0;

    // R8 data port write, new target
    wr32(10'h1C0, 32'h8000_1804, "R3");
    exp_cfg_addr = 32'h8000_1804; exp_cfg_wr = 1'b1; exp_cfg_wd = 32'h0BAD_F00D;
    cfg_allowed = 1'b1;
    wr32(10'h220, 32'h0BAD_F00D, "R8");
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    cfg_allowed = 1'b0;

    // R9 unlisted offsets
    wr32(10'h100, 32'hFFFF_FFFF, "R9");
    rd32(10'h100, 32'h0, "R9");
    wr32(10'h224, 32'hFFFF_FFFF, "R9");
    rd32(10'h224, 32'h0, "R9");
    rd32(10'h1CC, 32'h0, "R9");
    rd32(10'h0FC, 32'h1234_5678, "R9");
    rd32(10'h1C0, 32'h8000_1804, "R9");

    // R10 rejected accesses
    acc(1'b1, 10'h1C0, 4'b0011, 32'h1111_1111, 32'h0, 1'b1, "R10");
    rd32(10'h1C0, 32'h8000_1804, "R10");
    acc(1'b1, 10'h012, 4'hF, 32'h2222_2222, 32'h0, 1'b1, "R10");
    rd32(10'h010, 32'hDEAD_BEEF, "R10");
    acc(1'b0, 10'h010, 4'b1000, 32'h0, 32'h0, 1'b1, "R10");
    acc(1'b0, 10'h220, 4'b0001, 32'h0, 32'h0, 1'b1, "R10");
    repeat (4) @(negedge clk);

    // R11 interrupt steering
    irq_lvl = 8'b0000_0001; #1;
    check("R11", {29'h0, irq_out}, {29'h0, 4'b0010});
    irq_lvl = 8'b0000_0100; #1;
    check("R11", {29'h0, irq_out}, {29'h0, 4'b0000});
    irq_lvl = 8'b0000_1010; #1;
    check("R11", {29'h0, irq_out}, {29'h0, 4'b0101});
    irq_lvl = 8'b1111_0000; #1;
    check("R11", {29'h0, irq_out}, {29'h0, 4'b0000});

    repeat (3) @(negedge clk);
    check("R12", {1'b0, exp_q.size()}, 33'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule